// File: doc/BRIEF.md
# Six-Channel DMA Priority Arbiter

This block decides which of six DMA channels is served next when several of them are asking for a transfer at once. Each channel raises one bit of a request vector. Whenever no grant is outstanding and at least one request is present, the arbiter picks one channel and registers a one-hot grant with a valid flag. That grant stays in place until the transfer engine pulses a completion strobe to show that the granted channel has finished its transfer unit.

A two-bit mode input picks the selection policy at run time:

- a plain numeric fixed order;
- a second fixed order in which channel 1 drops below channels 2 and 3;
- a rotating order that puts the most recently served channel last.

The mode is sampled only at the moment of arbitration. Changing it while a grant is held therefore has no effect on that grant.

Top module: `dma_prio_arb`

## Requirements
- R1: While `gnt_vld` is high, `gnt` has exactly one bit set. Bit i of `gnt` stands for channel i.
- R2: When no grant is held and any `req` bit is high at a rising clock edge, that edge registers a grant to a channel whose request was high, and `gnt_vld` rises.
- R3: With `mode` = 2'b00, the lowest-numbered requesting channel wins. The order is 0, 1, 2, 3, 4, 5.
- R4: With `mode` = 2'b01, the order from highest priority is 0, 2, 3, 1, 4, 5.
- R5: With `mode` = 2'b10, priority rotates. The channel after the one that last completed (index plus one, with 5 wrapping to 0) is highest, and the order rises numerically from there with wrap-around. Every completion of a held grant moves this starting point, in any mode.
- R6: After reset, no grant is held, and the rotating order starts with channel 0 as highest priority.
- R7: A grant stays unchanged until `done` is sampled high while it is held. At that edge `gnt_vld` falls. A new arbitration can happen no earlier than the following edge, using the requests present then.
- R8: Changes to `mode` or `req` while a grant is held do not alter that grant. A new `mode` value applies from the next arbitration.
- R9: When no grant is held, `gnt_vld` is low and `gnt` is all zeros.
- R10: `mode` = 2'b11 is reserved and selects the same order as 2'b00.
- R11: A `done` pulse while no grant is held is ignored. In particular, it does not move the rotating order's starting point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req | input | 6 | Per-channel transfer request, bit i is channel i |
| mode | input | 2 | Priority policy: 00 fixed numeric, 01 fixed with channel 1 fourth, 10 rotating, 11 as 00 |
| done | input | 1 | Completion strobe for the channel currently granted |
| gnt | output | 6 | One-hot grant, all zeros when idle |
| gnt_vld | output | 1 | High while a grant is held |

## Verification
The arbiter has exactly one register stage:

- A request applied while the arbiter is idle shows up as a grant right after the next rising edge.
- A completion strobe clears the grant at the edge that samples it.
- The earliest next grant therefore follows one edge after that.

The bench drives every input on the falling edge and reads `gnt` and `gnt_vld` on the next falling edge, so each result is read half a period after the single edge that produces it. Its reference model updates its own copy of the rotation starting point only when it issues a completion for a held grant. The sweep covers all four mode codes against every non-zero request pattern, with the rotation point carried over from one arbitration to the next.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    MODE_FIX_NUM = 2'b00,
    MODE_FIX_SKW = 2'b01,
    MODE_ROTATE  = 2'b10,
    MODE_RSVD    = 2'b11
  } arb_mode_e;

  // Channel found at priority position pos (0 = highest) in the skewed fixed
  // order: channel 1 is placed after channels 2 and 3, the rest are numeric.
  function automatic int unsigned skew_chan_at(int unsigned pos);
    case (pos)
      1:       return 2;
      2:       return 3;
      3:       return 1;
      default: return pos;
    endcase
  endfunction

endpackage

// File: rtl/dma_arb_fixed.sv
module dma_arb_fixed
  import dma_arb_pkg::*;
#(
  parameter int N_CH  = 6,
  parameter int SKEW  = 0,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // Walk from lowest to highest priority so the last match wins.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int p = N_CH - 1; p >= 0; p--) begin
      int unsigned c;
      c = (SKEW != 0) ? skew_chan_at(p) : p;
      if (req[c]) begin
        hit = 1'b1;
        idx = IDX_W'(c);
      end
    end
  end

endmodule

// File: rtl/dma_arb_rotate.sv
module dma_arb_rotate #(
  parameter int N_CH  = 6,
  localparam int IDX_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0]  req,
  input  logic [IDX_W-1:0] head,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // head is the highest-priority channel; priority falls with wrap-around.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = N_CH - 1; k >= 0; k--) begin
      int unsigned c;
      c = int'(head) + k;
      if (c >= N_CH) c = c - N_CH;
      if (req[c]) begin
        hit = 1'b1;
        idx = IDX_W'(c);
      end
    end
  end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
#(
  parameter int N_CH  = 6,
  parameter int MODE_W = 2,
  localparam int IDX_W = $clog2(N_CH),
  localparam int N_FIX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   req,
  input  logic [MODE_W-1:0] mode,
  input  logic              done,
  output logic [N_CH-1:0]   gnt,
  output logic              gnt_vld
);

  // Fixed-order pickers, variant chosen by generate index
  logic [N_FIX-1:0]            fix_hit;
  logic [N_FIX-1:0][IDX_W-1:0] fix_idx;

  for (genvar g = 0; g < N_FIX; g++) begin : g_fix
    dma_arb_fixed #(.N_CH(N_CH), .SKEW(g)) u_fix (
      .req (req),
      .hit (fix_hit[g]),
      .idx (fix_idx[g])
    );
  end

  logic [IDX_W-1:0] head_q, head_d;
  logic             rot_hit;
  logic [IDX_W-1:0] rot_idx;

  dma_arb_rotate #(.N_CH(N_CH)) u_rot (
    .req  (req),
    .head (head_q),
    .hit  (rot_hit),
    .idx  (rot_idx)
  );

  // Policy selection
  arb_mode_e        cur_mode;
  logic             pick_hit;
  logic [IDX_W-1:0] pick_idx;

  always_comb begin
    cur_mode = arb_mode_e'(mode[1:0]);
    case (cur_mode)
      MODE_FIX_SKW: begin pick_hit = fix_hit[1]; pick_idx = fix_idx[1]; end
      MODE_ROTATE:  begin pick_hit = rot_hit;    pick_idx = rot_idx;    end
      default:      begin pick_hit = fix_hit[0]; pick_idx = fix_idx[0]; end
    endcase
  end

  // Next state
  logic             held_q, held_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en, head_en, held_en;
  logic             finish;

  assign finish  = held_q && done;
  assign idx_en  = !held_q && pick_hit;
  assign head_en = finish;
  assign held_en = finish || idx_en;

  always_comb begin
    held_d = held_q;
    idx_d  = idx_q;
    head_d = head_q;
    if (held_en) held_d = !held_q;
    if (idx_en)  idx_d  = pick_idx;
    if (head_en) head_d = (idx_q == IDX_W'(N_CH - 1)) ? '0 : idx_q + 1'b1;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      idx_q  <= '0;
      head_q <= '0;
    end else begin
      if (held_en) held_q <= held_d;
      if (idx_en)  idx_q  <= idx_d;
      if (head_en) head_q <= head_d;
    end
  end

  // Outputs
  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    assign gnt[i] = held_q && (idx_q == IDX_W'(i));
  end
  assign gnt_vld = held_q;

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
  parameter int N_CH   = 6,
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CH-1:0]   req,
  input logic [MODE_W-1:0] mode,
  input logic              done,
  input logic [N_CH-1:0]   gnt,
  input logic              gnt_vld
);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> ($countones(gnt) == 1)); // R1

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_vld |-> (gnt == '0)); // R9

  AST_ARB_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_vld && (req != '0)) |=> gnt_vld); // R2

  AST_GNT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_vld) |-> ((gnt & $past(req)) != '0)); // R2

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && !done) |=> (gnt_vld && $stable(gnt))); // R7

  AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && done) |=> !gnt_vld); // R7

endmodule

bind dma_prio_arb dma_prio_arb_chk #(.N_CH(N_CH), .MODE_W(MODE_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req     (req),
  .mode    (mode),
  .done    (done),
  .gnt     (gnt),
  .gnt_vld (gnt_vld)
);

// File: tb/tb_dma_prio_arb.sv
`timescale 1ns/1ps
module tb_dma_prio_arb;

  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] req;
  logic [1:0]    mode;
  logic          done;
  logic [NC-1:0] gnt;
  logic          gnt_vld;

  int n_chk  = 0;
  int n_fail = 0;
  int ptr    = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  dma_prio_arb dut (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .done(done),
    .gnt(gnt), .gnt_vld(gnt_vld)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Independent reference: channel chosen for request r in mode m with head p
  function automatic int exp_pick(logic [NC-1:0] r, int m, int p);
    int ord_b[NC] = '{0, 2, 3, 1, 4, 5};
    for (int k = 0; k < NC; k++) begin
      int c;
      c = (m == 1) ? ord_b[k] : (m == 2) ? (p + k) % NC : k;
      if (r[c]) return c;
    end
    return -1;
  endfunction

  task automatic expect_gnt(input int e, input string tag);
    check(gnt_vld === 1'b1, {tag, " vld"}, gnt_vld, 1);
    check(gnt === NC'(1 << e), {tag, " gnt"}, gnt, 1 << e);
  endtask

  // One full arbitration: request, grant, completion, release
  task automatic arb(input logic [NC-1:0] r, input int m, input string tag);
    int e;
    req = r; mode = 2'(m);
    step();
    e = exp_pick(r, m, ptr);
    expect_gnt(e, tag);
    done = 1'b1;
    step();
    check(gnt_vld === 1'b0 && gnt === '0, "R7 release", {gnt_vld, gnt}, 0);
    done = 1'b0; req = '0;
    ptr = (e + 1) % NC;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req = '0; mode = 2'b00; done = 1'b0;
    repeat (3) @(negedge clk);
    check(gnt_vld === 1'b0 && gnt === '0, "R6 reset idle", {gnt_vld, gnt}, 0);
    rst_n = 1'b1;
    step();
    check(gnt_vld === 1'b0 && gnt === '0, "R9 no request", {gnt_vld, gnt}, 0);

    // R6: rotating head starts at channel 0
    arb('1, 2, "R6 rotate after reset");

    // R11: stray completion while idle leaves head at 1
    done = 1'b1;
    step();
    done = 1'b0;
    check(gnt_vld === 1'b0, "R11 stray done idle", gnt_vld, 0);
    arb('1, 2, "R11 head unchanged");

    // R7/R8: held grant ignores request and mode changes
    req = 6'b001000; mode = 2'b00;
    step();
    expect_gnt(3, "R3 single");
    req = '1; mode = 2'b01;
    for (int i = 0; i < 4; i++) begin
      step();
      expect_gnt(3, "R8 hold");
    end
    done = 1'b1;
    step();
    check(gnt_vld === 1'b0, "R7 released", gnt_vld, 0);
    done = 1'b0;
    ptr = 4;
    step();
    expect_gnt(0, "R8 new mode applied");
    done = 1'b1;
    step();
    done = 1'b0; req = '0;
    ptr = 1;

    // Sweep all mode codes against every non-zero request pattern
    for (int m = 0; m < 4; m++) begin
      for (int r = 1; r < (1 << NC); r++) begin
        string tag;
        tag = (m == 0) ? "R3 sweep" : (m == 1) ? "R4 sweep" :
              (m == 2) ? "R5 sweep" : "R10 sweep";
        arb(NC'(r), m, tag);
      end
    end

    step();
    check(gnt_vld === 1'b0 && gnt === '0, "R9 final idle", {gnt_vld, gnt}, 0);
    finish_run();
  end

endmodule